// File: doc/BRIEF.md
# Exception Escalation and Shutdown Controller

This block watches exceptions and interrupts as a processor delivers them and decides what to do with each new event. It sorts the event into one of three classes: benign, contributory or page fault. It then compares that class with the class of the handler being dispatched at that moment. From that comparison it either passes the event on unchanged (serial handling), replaces it with a double fault (vector 8, error code zero), or, when the double-fault handler itself is interrupted, enters a halted shutdown state and announces this with a one-cycle bus-message strobe.

The surrounding core presents each event with a valid strobe, its vector, and a flag that marks software interrupts and external interrupt requests. It holds a dispatch-busy level while a handler is being entered and pulses dispatch-done once entry has finished. While the block is in shutdown it delivers nothing. Only a wake request releases it: reset, init, SMI or NMI, granted by fixed priority. If shutdown was entered while an NMI handler was running, only reset releases it. A synchronous reset wake input clears all state in any mode. A separate asynchronous chip reset initialises the registers.

Top module: `exc_escalate_ctrl`

## Requirements
- R1: An event with `evt_ext`=1 is benign whatever its vector. With `evt_ext`=0, vectors 0, 10, 11, 12 and 13 are contributory, vector 14 is a page fault, and every other vector is benign.
- R2: An event arrives while the tracker is idle, or while `dispatch_busy` is low. It is a first event: one cycle later `deliver_valid` pulses for one cycle with `deliver_vector` equal to the event vector.
- R3: A nested event (one that arrives with `dispatch_busy` high) produces a double fault in two cases: it is contributory while a contributory handler is being dispatched, or it is contributory or a page fault while a page-fault handler is being dispatched. One cycle later the block delivers vector 8 with `err_valid`=1 and `err_code`=0.
- R4: The other nested combinations are handled serially, with the event's own vector delivered and no error-code valid. These are a page fault during contributory dispatch and any pairing in which either the first event or the second event is benign.
- R5: A nested event while the double-fault handler is being dispatched delivers nothing. One cycle later `shutdown` rises and `shutdown_msg` is high for exactly that one cycle.
- R6: While in shutdown, events produce no delivery and `shutdown` stays high.
- R7: In shutdown, the wake priority is reset > init > SMI > NMI. The granted source appears on `wake_grant` for one cycle, one-hot, in the cycle after the request: bit0 NMI, bit1 SMI, bit2 INIT, bit3 RESET. `shutdown` is low in that same cycle.
- R8: If `nmi_ctx` is high in the cycle that causes shutdown, NMI, SMI and INIT requests are ignored in shutdown, and only `wake_reset` releases the block (grant bit3).
- R9: `dispatch_done` returns the tracker to idle, so the next event is a first event. An event in the same cycle as `dispatch_done` is also a first event.
- R10: `wake_reset` clears all state and outranks an event in the same cycle, which is then not delivered. Outside shutdown it gives no grant, and NMI, SMI and INIT requests outside shutdown have no effect.
- R11: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| evt_valid | input | 1 | New event strobe |
| evt_vector | input | VEC_W | Event vector |
| evt_ext | input | 1 | Event is a software interrupt or an external interrupt request |
| dispatch_busy | input | 1 | A handler is being dispatched |
| dispatch_done | input | 1 | Handler dispatch finished |
| nmi_ctx | input | 1 | An NMI handler is currently running |
| wake_nmi | input | 1 | NMI wake request |
| wake_smi | input | 1 | SMI wake request |
| wake_init | input | 1 | INIT wake request |
| wake_reset | input | 1 | Synchronous reset and wake request |
| deliver_valid | output | 1 | A vector is delivered this cycle |
| deliver_vector | output | VEC_W | Vector to deliver |
| err_valid | output | 1 | An error code is pushed with this delivery |
| err_code | output | ERR_W | Pushed error code |
| shutdown | output | 1 | Block is in shutdown |
| shutdown_msg | output | 1 | One-cycle shutdown bus message |
| wake_grant | output | 4 | One-hot granted wake source |

## Verification
Every result is registered once, so it is due in the first cycle after the stimulus that causes it. This holds for deliveries, double-fault substitutions, the shutdown rise with its message strobe, and wake grants together with the shutdown drop. The driver applies one stimulus per cycle on the falling edge and queues the expected outputs for that cycle. The monitor pops one entry a quarter period after each rising edge, so each comparison falls in exactly the cycle in which that stimulus has taken effect. Cycles in which an output must stay idle are queued as well, which checks one-cycle pulses and ignored inputs in the cycles that follow them.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [1:0] {
    CLS_BENIGN  = 2'd0,
    CLS_CONTRIB = 2'd1,
    CLS_PAGE    = 2'd2
  } exc_cls_e;

  typedef enum logic [2:0] {
    NS_IDLE    = 3'd0,
    NS_BENIGN  = 3'd1,
    NS_CONTRIB = 3'd2,
    NS_PAGE    = 3'd3,
    NS_DOUBLE  = 3'd4,
    NS_HALT    = 3'd5
  } nest_e;

  localparam int unsigned WAKE_N  = 4;
  localparam int unsigned WK_NMI  = 0;
  localparam int unsigned WK_SMI  = 1;
  localparam int unsigned WK_INIT = 2;
  localparam int unsigned WK_RST  = 3;

  function automatic nest_e cls_to_state(input exc_cls_e c);
    case (c)
      CLS_CONTRIB: cls_to_state = NS_CONTRIB;
      CLS_PAGE:    cls_to_state = NS_PAGE;
      default:     cls_to_state = NS_BENIGN;
    endcase
  endfunction

endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_pkg::*;
#(
  parameter int unsigned VEC_W      = 8,
  parameter int unsigned DE_VEC     = 0,
  parameter int unsigned CONTRIB_LO = 10,
  parameter int unsigned CONTRIB_HI = 13,
  parameter int unsigned PF_VEC     = 14
) (
  input  logic [VEC_W-1:0] vec,
  input  logic             ext,
  output exc_cls_e         cls
);

  localparam logic [VEC_W-1:0] DE_V = VEC_W'(DE_VEC);
  localparam logic [VEC_W-1:0] LO_V = VEC_W'(CONTRIB_LO);
  localparam logic [VEC_W-1:0] HI_V = VEC_W'(CONTRIB_HI);
  localparam logic [VEC_W-1:0] PF_V = VEC_W'(PF_VEC);

  always_comb begin
    if (ext) begin
      cls = CLS_BENIGN;
    end else if (vec == DE_V || (vec >= LO_V && vec <= HI_V)) begin
      cls = CLS_CONTRIB;
    end else if (vec == PF_V) begin
      cls = CLS_PAGE;
    end else begin
      cls = CLS_BENIGN;
    end
  end

endmodule

// File: rtl/exc_wake_arb.sv
module exc_wake_arb
  import exc_pkg::*;
(
  input  logic [WAKE_N-1:0] req,
  input  logic              reset_only,
  output logic [WAKE_N-1:0] grant
);

  logic [WAKE_N-1:0] eligible;

  always_comb begin
    eligible = req;
    if (reset_only) begin
      eligible = req & (WAKE_N'(1) << WK_RST);
    end
  end

  // highest index wins: reset, init, smi, nmi
  always_comb begin
    grant = '0;
    for (int i = WAKE_N - 1; i >= 0; i--) begin
      if (eligible[i] && grant == '0) begin
        grant[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/exc_nest_fsm.sv
module exc_nest_fsm
  import exc_pkg::*;
#(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned DF_VEC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [VEC_W-1:0]  evt_vector,
  input  exc_cls_e          evt_cls,
  input  logic              dispatch_busy,
  input  logic              dispatch_done,
  input  logic              nmi_ctx,
  input  logic              wake_reset,
  input  logic [WAKE_N-1:0] grant_in,
  output logic              reset_only,
  output logic              deliver_valid,
  output logic [VEC_W-1:0]  deliver_vector,
  output logic              err_valid,
  output logic              shutdown,
  output logic              shutdown_msg,
  output logic [WAKE_N-1:0] wake_grant
);

  localparam logic [VEC_W-1:0] DF_V = VEC_W'(DF_VEC);

  nest_e             st_q, st_d, base;
  logic              lock_q, lock_d;
  logic              dv_q, dv_d;
  logic [VEC_W-1:0]  vec_q, vec_d;
  logic              ev_q, ev_d;
  logic              msg_q, msg_d;
  logic [WAKE_N-1:0] grant_q, grant_d;
  logic              nested;
  logic              escalate;

  always_comb begin
    st_d     = st_q;
    lock_d   = lock_q;
    dv_d     = 1'b0;
    vec_d    = vec_q;
    ev_d     = 1'b0;
    msg_d    = 1'b0;
    grant_d  = '0;
    base     = (dispatch_done) ? NS_IDLE : st_q;
    nested   = (base != NS_IDLE) && dispatch_busy;
    escalate = nested &&
               (((base == NS_CONTRIB) && (evt_cls == CLS_CONTRIB)) ||
                ((base == NS_PAGE) && (evt_cls != CLS_BENIGN)));
    if (wake_reset) begin
      st_d   = NS_IDLE;
      lock_d = 1'b0;
      vec_d  = '0;
      if (st_q == NS_HALT) begin
        grant_d = grant_in;
      end
    end else if (st_q == NS_HALT) begin
      if (|grant_in) begin
        st_d    = NS_IDLE;
        lock_d  = 1'b0;
        grant_d = grant_in;
      end
    end else begin
      st_d = base;
      if (evt_valid) begin
        if (nested && (base == NS_DOUBLE)) begin
          st_d   = NS_HALT;
          msg_d  = 1'b1;
          lock_d = nmi_ctx;
        end else if (escalate) begin
          st_d  = NS_DOUBLE;
          dv_d  = 1'b1;
          vec_d = DF_V;
          ev_d  = 1'b1;
        end else begin
          st_d  = cls_to_state(evt_cls);
          dv_d  = 1'b1;
          vec_d = evt_vector;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= NS_IDLE;
      lock_q  <= 1'b0;
      dv_q    <= 1'b0;
      vec_q   <= '0;
      ev_q    <= 1'b0;
      msg_q   <= 1'b0;
      grant_q <= '0;
    end else begin
      st_q    <= st_d;
      lock_q  <= lock_d;
      dv_q    <= dv_d;
      ev_q    <= ev_d;
      msg_q   <= msg_d;
      grant_q <= grant_d;
      if (dv_d || wake_reset) begin
        vec_q <= vec_d;
      end
    end
  end

  assign reset_only     = lock_q;
  assign deliver_valid  = dv_q;
  assign deliver_vector = vec_q;
  assign err_valid      = ev_q;
  assign shutdown       = (st_q == NS_HALT);
  assign shutdown_msg   = msg_q;
  assign wake_grant     = grant_q;

endmodule

// File: rtl/exc_escalate_ctrl.sv
module exc_escalate_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned ERR_W  = 32,
  parameter int unsigned DF_VEC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [VEC_W-1:0]  evt_vector,
  input  logic              evt_ext,
  input  logic              dispatch_busy,
  input  logic              dispatch_done,
  input  logic              nmi_ctx,
  input  logic              wake_nmi,
  input  logic              wake_smi,
  input  logic              wake_init,
  input  logic              wake_reset,
  output logic              deliver_valid,
  output logic [VEC_W-1:0]  deliver_vector,
  output logic              err_valid,
  output logic [ERR_W-1:0]  err_code,
  output logic              shutdown,
  output logic              shutdown_msg,
  output logic [3:0]        wake_grant
);

  exc_cls_e          cls;
  logic [WAKE_N-1:0] wake_req;
  logic [WAKE_N-1:0] grant_c;
  logic              reset_only;

  always_comb begin
    wake_req          = '0;
    wake_req[WK_NMI]  = wake_nmi;
    wake_req[WK_SMI]  = wake_smi;
    wake_req[WK_INIT] = wake_init;
    wake_req[WK_RST]  = wake_reset;
  end

  exc_classify #(.VEC_W(VEC_W)) i_classify (
    .vec (evt_vector),
    .ext (evt_ext),
    .cls (cls)
  );

  exc_wake_arb i_wake_arb (
    .req        (wake_req),
    .reset_only (reset_only),
    .grant      (grant_c)
  );

  exc_nest_fsm #(.VEC_W(VEC_W), .DF_VEC(DF_VEC)) i_nest_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .evt_valid      (evt_valid),
    .evt_vector     (evt_vector),
    .evt_cls        (cls),
    .dispatch_busy  (dispatch_busy),
    .dispatch_done  (dispatch_done),
    .nmi_ctx        (nmi_ctx),
    .wake_reset     (wake_reset),
    .grant_in       (grant_c),
    .reset_only     (reset_only),
    .deliver_valid  (deliver_valid),
    .deliver_vector (deliver_vector),
    .err_valid      (err_valid),
    .shutdown       (shutdown),
    .shutdown_msg   (shutdown_msg),
    .wake_grant     (wake_grant)
  );

  // the double fault is the only code source in this block and it is zero
  assign err_code = '0;

endmodule

// File: rtl/exc_escalate_chk.sv
module exc_escalate_chk #(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned ERR_W  = 32,
  parameter int unsigned DF_VEC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wake_reset,
  input logic             deliver_valid,
  input logic [VEC_W-1:0] deliver_vector,
  input logic             err_valid,
  input logic [ERR_W-1:0] err_code,
  input logic             shutdown,
  input logic             shutdown_msg,
  input logic [3:0]       wake_grant
);

  assert_df_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (deliver_valid && deliver_vector == VEC_W'(DF_VEC) && err_code == '0));

  assert_msg_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_msg |-> $rose(shutdown));

  assert_quiet_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> !deliver_valid);

  assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake_grant));

  assert_grant_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|wake_grant) |-> (!shutdown && $past(shutdown)));

  assert_sync_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_reset |=> (!shutdown && !deliver_valid && !err_valid));

endmodule

bind exc_escalate_ctrl exc_escalate_chk #(
  .VEC_W(VEC_W), .ERR_W(ERR_W), .DF_VEC(DF_VEC)
) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wake_reset     (wake_reset),
  .deliver_valid  (deliver_valid),
  .deliver_vector (deliver_vector),
  .err_valid      (err_valid),
  .err_code       (err_code),
  .shutdown       (shutdown),
  .shutdown_msg   (shutdown_msg),
  .wake_grant     (wake_grant)
);

// File: tb/test_exc_escalate_ctrl.sv
module test_exc_escalate_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_valid, evt_ext, dispatch_busy, dispatch_done, nmi_ctx;
  logic [7:0]  evt_vector;
  logic        wake_nmi, wake_smi, wake_init, wake_reset;
  logic        deliver_valid, err_valid, shutdown, shutdown_msg;
  logic [7:0]  deliver_vector;
  logic [31:0] err_code;
  logic [3:0]  wake_grant;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic       dv;
    logic [7:0] vec;
    logic       ev;
    logic       sd;
    logic       msg;
    logic [3:0] grant;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t e;

  always #10 clk = ~clk;

  exc_escalate_ctrl i_exc_escalate_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_vector(evt_vector),
    .evt_ext(evt_ext), .dispatch_busy(dispatch_busy), .dispatch_done(dispatch_done),
    .nmi_ctx(nmi_ctx), .wake_nmi(wake_nmi), .wake_smi(wake_smi), .wake_init(wake_init),
    .wake_reset(wake_reset), .deliver_valid(deliver_valid), .deliver_vector(deliver_vector),
    .err_valid(err_valid), .err_code(err_code), .shutdown(shutdown),
    .shutdown_msg(shutdown_msg), .wake_grant(wake_grant)
  );

  // monitor: one expected entry per cycle, sampled a quarter period after the edge
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (deliver_valid !== e.dv || err_valid !== e.ev || shutdown !== e.sd ||
          shutdown_msg !== e.msg || wake_grant !== e.grant ||
          (e.dv && deliver_vector !== e.vec) || (e.ev && err_code !== 32'd0)) begin
        errors++;
        $display("FAIL %s: got dv=%0b vec=%0d ev=%0b code=%0h sd=%0b msg=%0b grant=%b exp dv=%0b vec=%0d ev=%0b code=0 sd=%0b msg=%0b grant=%b",
                 e.tag, deliver_valid, deliver_vector, err_valid, err_code, shutdown,
                 shutdown_msg, wake_grant, e.dv, e.vec, e.ev, e.sd, e.msg, e.grant);
      end
    end
  end

  task automatic step(input logic v, input logic [7:0] vec, input logic ext,
                      input logic busy, input logic dn, input logic [3:0] wk,
                      input logic nctx, input logic xdv, input logic [7:0] xvec,
                      input logic xev, input logic xsd, input logic xmsg,
                      input logic [3:0] xgr, input string tag);
    exp_t x;
    @(negedge clk);
    evt_valid = v; evt_vector = vec; evt_ext = ext; dispatch_busy = busy;
    dispatch_done = dn; nmi_ctx = nctx;
    {wake_reset, wake_init, wake_smi, wake_nmi} = wk;
    x.dv = xdv; x.vec = xvec; x.ev = xev; x.sd = xsd; x.msg = xmsg; x.grant = xgr; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic evt(input logic [7:0] vec, input logic ext, input logic busy,
                     input logic [7:0] xvec, input logic xev, input string tag);
    step(1, vec, ext, busy, 0, 4'b0000, 0, 1, xvec, xev, 0, 0, 4'b0000, tag);
  endtask

  task automatic done_step(input string tag);
    step(0, 0, 0, 0, 1, 4'b0000, 0, 0, 0, 0, 0, 0, 4'b0000, tag);
  endtask

  // contributory, double fault, then a nested event: shutdown
  task automatic to_halt(input logic nctx, input string tag);
    evt(8'd13, 0, 0, 8'd13, 0, tag);
    evt(8'd0, 0, 1, 8'd8, 1, tag);
    step(1, 8'd3, 0, 1, 0, 4'b0000, nctx, 0, 0, 0, 1, 1, 4'b0000, tag);
  endtask

  initial begin
    rst_n = 1'b0;
    evt_valid = 0; evt_vector = 0; evt_ext = 0; dispatch_busy = 0;
    dispatch_done = 0; nmi_ctx = 0;
    wake_nmi = 0; wake_smi = 0; wake_init = 0; wake_reset = 0;
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (deliver_valid !== 0 || err_valid !== 0 || shutdown !== 0 ||
        shutdown_msg !== 0 || wake_grant !== 0) begin
      errors++;
      $display("FAIL R11: got dv=%0b ev=%0b sd=%0b msg=%0b grant=%b exp all zero",
               deliver_valid, err_valid, shutdown, shutdown_msg, wake_grant);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2 first event delivered unchanged, single-cycle pulse
    evt(8'd3, 0, 0, 8'd3, 0, "R2 first benign");
    step(0, 0, 0, 1, 0, 4'b0000, 0, 0, 0, 0, 0, 0, 4'b0000, "R2 pulse ends");
    done_step("R9 done");
    // R3 contributory during contributory
    evt(8'd13, 0, 0, 8'd13, 0, "R1 vec13 contrib");
    evt(8'd0, 0, 1, 8'd8, 1, "R3 contrib+contrib");
    done_step("R9 done");
    // R3 page fault during page fault
    evt(8'd14, 0, 0, 8'd14, 0, "R1 vec14 page");
    evt(8'd14, 0, 1, 8'd8, 1, "R3 page+page");
    done_step("R9 done");
    // R3 contributory during page fault
    evt(8'd14, 0, 0, 8'd14, 0, "R1 page first");
    evt(8'd11, 0, 1, 8'd8, 1, "R3 page+contrib");
    done_step("R9 done");
    // R4 page fault during contributory
    evt(8'd12, 0, 0, 8'd12, 0, "R1 vec12 contrib");
    evt(8'd14, 0, 1, 8'd14, 0, "R4 contrib+page serial");
    done_step("R9 done");
    // R4 benign then contributory, then contributory then benign
    evt(8'd6, 0, 0, 8'd6, 0, "R1 vec6 benign");
    evt(8'd10, 0, 1, 8'd10, 0, "R4 benign+contrib serial");
    evt(8'd3, 0, 1, 8'd3, 0, "R4 contrib+benign serial");
    done_step("R9 done");
    // R1 external flag makes vector 13 benign
    evt(8'd13, 1, 0, 8'd13, 0, "R1 ext first");
    evt(8'd13, 0, 1, 8'd13, 0, "R1 ext benign then contrib serial");
    done_step("R9 done");
    // R2 busy low makes the second event a first one
    evt(8'd13, 0, 0, 8'd13, 0, "R2 setup");
    evt(8'd13, 0, 0, 8'd13, 0, "R2 busy low first");
    done_step("R9 done");
    // R9 done strobe returns to idle
    evt(8'd13, 0, 0, 8'd13, 0, "R9 setup");
    done_step("R9 done alone");
    evt(8'd13, 0, 1, 8'd13, 0, "R9 after done first");
    // R9 done and event in the same cycle
    step(1, 8'd0, 0, 1, 1, 4'b0000, 0, 1, 8'd0, 0, 0, 0, 4'b0000, "R9 done with event");
    done_step("R9 done");

    // R5 shutdown entry, R6 ignored events, R7 SMI beats NMI
    to_halt(0, "R5 enter");
    step(0, 0, 0, 1, 0, 4'b0000, 0, 0, 0, 0, 1, 0, 4'b0000, "R5 msg one cycle");
    step(1, 8'd13, 0, 1, 0, 4'b0000, 0, 0, 0, 0, 1, 0, 4'b0000, "R6 event ignored");
    step(0, 0, 0, 0, 1, 4'b0000, 0, 0, 0, 0, 1, 0, 4'b0000, "R6 done ignored");
    step(0, 0, 0, 0, 0, 4'b0011, 0, 0, 0, 0, 0, 0, 4'b0010, "R7 smi over nmi");
    step(0, 0, 0, 0, 0, 4'b0000, 0, 0, 0, 0, 0, 0, 4'b0000, "R7 grant one cycle");
    evt(8'd13, 0, 1, 8'd13, 0, "R7 idle after wake");
    done_step("R9 done");
    // R7 reset beats all; init beats nmi; nmi alone
    to_halt(0, "R5 enter");
    step(0, 0, 0, 0, 0, 4'b1111, 0, 0, 0, 0, 0, 0, 4'b1000, "R7 reset first");
    to_halt(0, "R5 enter");
    step(0, 0, 0, 0, 0, 4'b0101, 0, 0, 0, 0, 0, 0, 4'b0100, "R7 init over nmi");
    to_halt(0, "R5 enter");
    step(0, 0, 0, 0, 0, 4'b0001, 0, 0, 0, 0, 0, 0, 4'b0001, "R7 nmi alone");
    // R8 NMI context at entry: only reset releases
    to_halt(1, "R8 enter");
    step(0, 0, 0, 0, 0, 4'b0111, 0, 0, 0, 0, 1, 0, 4'b0000, "R8 wakes refused");
    step(0, 0, 0, 0, 0, 4'b1000, 0, 0, 0, 0, 0, 0, 4'b1000, "R8 reset releases");
    // R10 reset mid-dispatch clears the tracker, no grant
    evt(8'd13, 0, 0, 8'd13, 0, "R10 setup");
    step(0, 0, 0, 1, 0, 4'b1000, 0, 0, 0, 0, 0, 0, 4'b0000, "R10 reset no grant");
    evt(8'd13, 0, 1, 8'd13, 0, "R10 tracker cleared");
    // R10 reset outranks a same-cycle event
    step(1, 8'd0, 0, 1, 0, 4'b1000, 0, 0, 0, 0, 0, 0, 4'b0000, "R10 reset beats event");
    evt(8'd0, 0, 1, 8'd0, 0, "R10 still idle");
    // R10 wakes outside shutdown have no effect
    step(0, 0, 0, 1, 0, 4'b0111, 0, 0, 0, 0, 0, 0, 4'b0000, "R10 wake outside halt");
    evt(8'd12, 0, 1, 8'd8, 1, "R10 tracker kept after wakes");
    done_step("R9 done");

    repeat (3) @(posedge clk);
    #8;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule